// File: doc/BRIEF.md
# DRAM Parallel Test Mode Controller

This block plays the memory-device side of an asynchronous row/column strobe interface. Its purpose is to let a memory controller be checked against the device's special test behaviour. A fast system clock samples the active-low row strobe, column strobe and write-enable through two-stage synchronizers. The address and data inputs go through the same synchronizers. Each row-strobe cycle is then classified as one of three kinds: a normal access, a refresh that enters test mode, or a refresh that leaves it.

The block holds a small cell array with its own storage. The array is organised as rows by columns by DQ bits. In normal mode a column access reads or writes one word, and several column accesses may share one open row.

Once test mode is latched, the lowest column-address bit no longer matters, so every DQ covers a pair of cells. A write puts the DQ value into both cells of the pair. A read returns, per DQ, a 1 when the two cells agree and a 0 when they differ. A test read also arrives a fixed number of clock cycles later than a normal read.

An error-injection port flips a single stored bit. With it, a bench can make a compressed read fail on purpose.

Top module: `dram_ptest`

## Requirements
- R1: While reset is asserted and right after it, `test_mode` is 0, `dq_oe` is 0 and `dq_out` is 0.
- R2: A row-strobe fall with the column strobe already low and write-enable low sets `test_mode` to 1, provided write-enable meets its setup and hold windows.
- R3: `test_mode` keeps its value through normal access cycles and through any number of column accesses; it can change only inside a row-strobe cycle.
- R4: A row-strobe fall with the column strobe low and write-enable high clears `test_mode`.
- R5: A row-strobe cycle in which the column strobe never falls clears `test_mode` when the row strobe rises.
- R6: If write-enable is not low in the synchronized sample at the row-strobe fall and in the `WE_SETUP_CYC` samples before it, the cycle is a plain refresh: `test_mode` ends 0.
- R7: If write-enable rises within `WE_HOLD_CYC` samples after the row-strobe fall, the cycle is a plain refresh: `test_mode` ends 0.
- R8: In normal mode a column access with write-enable low stores `dq_in` at (row, column), and a read returns that word on `dq_out`; several columns may be accessed within one open row.
- R9: In test mode, column-address bit 0 is ignored: a write stores `dq_in` into both columns {col[COL_W-1:1],0} and {col[COL_W-1:1],1} of the open row.
- R10: In a test-mode read, bit i of `dq_out` is 1 when bit i of the even and odd cells of the pair are equal and 0 when they differ.
- R11: A test-mode read raises `dq_oe` exactly `TEST_EXTRA_CYC` clock cycles later than a normal read, counted from the column-strobe fall.
- R12: `dq_oe` is 1 only for reads and only while the column strobe is low; it stays 0 through writes, and `dq_out` is 0 whenever `dq_oe` is 0.
- R13: A one-cycle pulse on `inj_en` inverts exactly the stored bit `inj_bit` at (`inj_row`, `inj_col`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| inj_en | input | 1 | One-cycle pulse that flips one stored bit |
| inj_row | input | ROW_W | Row of the bit to flip |
| inj_col | input | COL_W | Column of the bit to flip |
| inj_bit | input | DQW_B | DQ index of the bit to flip |
| dq_out | output | DQ_W | Read data, or per-DQ compare result in test mode |
| dq_oe | output | 1 | Read data valid / output enable |
| test_mode | output | 1 | Latched test-mode flag |

## Verification
Every cycle, the assertions check four things:
- A rise of `test_mode` happens only while the synchronized row strobe and write-enable are both low.
- The flag changes only inside a row-strobe cycle.
- `dq_oe` is never high with the column strobe released.
- The read-enable rise sits two cycles after the column event in normal mode, and later than that in test mode.

Some properties can only be shown by the bench's scenarios, because they depend on array contents:
- The stored values.
- The pair write.
- The equal/differ compression pattern after an injected flip.
- The exact one-cycle latency difference.
- The outcomes of late-setup and short-hold entry attempts.

// File: rtl/dtpm_pkg.sv
package dtpm_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACCESS  = 2'd1,
    CYC_REFRESH = 2'd2,
    CYC_ENTRY   = 2'd3
  } cyc_state_e;

endpackage

// File: rtl/dtpm_sync.sv
module dtpm_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_async[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/dtpm_cycle_decoder.sv
module dtpm_cycle_decoder
  import dtpm_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int ROW_W        = 2,
  parameter int COL_W        = 3,
  parameter int WE_SETUP_CYC = 2,
  parameter int WE_HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_s,
  input  logic              cas_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              test_mode,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              acc_go,
  output logic              acc_wr,
  output logic              out_drop,
  output logic              ras_prev,
  output logic              cas_prev
);

  localparam int HCW = (WE_HOLD_CYC > 1) ? $clog2(WE_HOLD_CYC) : 1;
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(WE_HOLD_CYC - 1);

  cyc_state_e st_q, st_d;
  logic ras_p_q, cas_p_q;
  logic [WE_SETUP_CYC-1:0] we_hist_q, we_hist_d;
  logic [HCW-1:0] hold_q, hold_d;
  logic tm_q, tm_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic seen_q, seen_d;

  logic ras_fall, ras_rise, cas_fall, cas_rise, setup_ok;

  assign ras_fall = ras_p_q & ~ras_s;
  assign ras_rise = ~ras_p_q & ras_s;
  assign cas_fall = cas_p_q & ~cas_s;
  assign cas_rise = ~cas_p_q & cas_s;

  // Write-enable history: samples before the current one
  if (WE_SETUP_CYC > 1) begin : g_hist_wide
    assign we_hist_d = {we_hist_q[WE_SETUP_CYC-2:0], we_s};
  end else begin : g_hist_one
    assign we_hist_d = we_s;
  end

  assign setup_ok = (we_hist_q == '0) & ~we_s;

  always_comb begin
    st_d   = st_q;
    tm_d   = tm_q;
    hold_d = hold_q;
    row_d  = row_q;
    seen_d = seen_q;
    unique case (st_q)
      CYC_IDLE: begin
        if (ras_fall) begin
          if (!cas_s) begin
            if (setup_ok) begin
              st_d   = CYC_ENTRY;
              hold_d = '0;
            end else begin
              st_d = CYC_REFRESH;
              tm_d = 1'b0;
            end
          end else begin
            st_d   = CYC_ACCESS;
            row_d  = addr_s[ROW_W-1:0];
            seen_d = 1'b0;
          end
        end
      end
      CYC_ACCESS: begin
        if (cas_fall) seen_d = 1'b1;
        if (ras_rise) begin
          if (!(seen_q | cas_fall)) tm_d = 1'b0;
          st_d = CYC_IDLE;
        end
      end
      CYC_ENTRY: begin
        if (we_s) begin
          tm_d = 1'b0;
          st_d = ras_rise ? CYC_IDLE : CYC_REFRESH;
        end else if (ras_rise) begin
          tm_d = 1'b0;
          st_d = CYC_IDLE;
        end else if (hold_q == HOLD_LAST) begin
          tm_d = 1'b1;
          st_d = CYC_REFRESH;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
      CYC_REFRESH: begin
        if (ras_rise) st_d = CYC_IDLE;
      end
      default: st_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= CYC_IDLE;
      ras_p_q   <= 1'b1;
      cas_p_q   <= 1'b1;
      we_hist_q <= '1;
      hold_q    <= '0;
      tm_q      <= 1'b0;
      row_q     <= '0;
      seen_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      ras_p_q   <= ras_s;
      cas_p_q   <= cas_s;
      we_hist_q <= we_hist_d;
      hold_q    <= hold_d;
      tm_q      <= tm_d;
      row_q     <= row_d;
      seen_q    <= seen_d;
    end
  end

  assign test_mode = tm_q;
  assign row       = row_q;
  assign col       = addr_s[COL_W-1:0];
  assign acc_go    = (st_q == CYC_ACCESS) & cas_fall;
  assign acc_wr    = ~we_s;
  assign out_drop  = cas_rise | ras_rise;
  assign ras_prev  = ras_p_q;
  assign cas_prev  = cas_p_q;

endmodule

// File: rtl/dtpm_cell_array.sv
module dtpm_cell_array #(
  parameter int ROW_W = 2,
  parameter int COL_W = 3,
  parameter int DQ_W  = 4,
  parameter int DQW_B = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             acc_go,
  input  logic             acc_wr,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [DQ_W-1:0]  wdata,
  input  logic             inj_en,
  input  logic [ROW_W-1:0] inj_row,
  input  logic [COL_W-1:0] inj_col,
  input  logic [DQW_B-1:0] inj_bit,
  output logic             rd_go,
  output logic [DQ_W-1:0]  rdata
);

  localparam int WORDS = 2 ** (ROW_W + COL_W);
  localparam int IDX_W = ROW_W + COL_W;

  logic [WORDS-1:0][DQ_W-1:0] mem_q, mem_d;
  logic mem_en;
  logic [COL_W-1:0] col_ev, col_od;
  logic [IDX_W-1:0] idx_ev, idx_od, idx_nm, idx_inj;
  logic [DQ_W-1:0] word_ev, word_od;

  assign col_ev  = {col[COL_W-1:1], 1'b0};
  assign col_od  = {col[COL_W-1:1], 1'b1};
  assign idx_ev  = {row, col_ev};
  assign idx_od  = {row, col_od};
  assign idx_nm  = {row, col};
  assign idx_inj = {inj_row, inj_col};
  assign word_ev = mem_q[idx_ev];
  assign word_od = mem_q[idx_od];

  assign mem_en = (acc_go & acc_wr) | inj_en;

  always_comb begin
    mem_d = mem_q;
    if (acc_go && acc_wr) begin
      if (test_mode) begin
        mem_d[idx_ev] = wdata;
        mem_d[idx_od] = wdata;
      end else begin
        mem_d[idx_nm] = wdata;
      end
    end
    if (inj_en) begin
      mem_d[idx_inj][inj_bit] = ~mem_d[idx_inj][inj_bit];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  assign rd_go = acc_go & ~acc_wr;
  assign rdata = test_mode ? ~(word_ev ^ word_od) : mem_q[idx_nm];

endmodule

// File: rtl/dtpm_dq_driver.sv
module dtpm_dq_driver #(
  parameter int DQ_W           = 4,
  parameter int TEST_EXTRA_CYC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_mode,
  input  logic            rd_go,
  input  logic [DQ_W-1:0] rdata,
  input  logic            drop,
  output logic            dq_oe,
  output logic [DQ_W-1:0] dq_out
);

  localparam int CW = (TEST_EXTRA_CYC > 0) ? $clog2(TEST_EXTRA_CYC + 1) : 1;
  localparam logic [CW-1:0] EXTRA = CW'(TEST_EXTRA_CYC);

  logic [DQ_W-1:0] data_q;
  logic pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic oe_q, oe_d;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    oe_d   = oe_q;
    if (drop) begin
      pend_d = 1'b0;
      oe_d   = 1'b0;
    end else if (rd_go) begin
      pend_d = 1'b1;
      cnt_d  = test_mode ? EXTRA : '0;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        oe_d   = 1'b1;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      oe_q   <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_go) begin
      data_q <= rdata;
    end
  end

  assign dq_oe  = oe_q;
  assign dq_out = oe_q ? data_q : '0;

endmodule

// File: rtl/dram_ptest.sv
module dram_ptest #(
  parameter int ADDR_W         = 3,
  parameter int ROW_W          = 2,
  parameter int COL_W          = 3,
  parameter int DQ_W           = 4,
  parameter int DQW_B          = 2,
  parameter int WE_SETUP_CYC   = 2,
  parameter int WE_HOLD_CYC    = 2,
  parameter int TEST_EXTRA_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic              inj_en,
  input  logic [ROW_W-1:0]  inj_row,
  input  logic [COL_W-1:0]  inj_col,
  input  logic [DQW_B-1:0]  inj_bit,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              test_mode
);

  localparam int BUS_W = ADDR_W + DQ_W;

  logic ras_s, cas_s, we_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DQ_W-1:0] dq_s;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic acc_go, acc_wr, out_drop, ras_p, cas_p;
  logic rd_go;
  logic [DQ_W-1:0] rdata;

  dtpm_sync #(.W(3), .RST_VAL(3'b111)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({ras_n, cas_n, we_n}),
    .q_sync({ras_s, cas_s, we_s})
  );

  dtpm_sync #(.W(BUS_W), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({addr, dq_in}),
    .q_sync({addr_s, dq_s})
  );

  dtpm_cycle_decoder #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .WE_SETUP_CYC(WE_SETUP_CYC), .WE_HOLD_CYC(WE_HOLD_CYC)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .ras_s(ras_s), .cas_s(cas_s), .we_s(we_s), .addr_s(addr_s),
    .test_mode(test_mode), .row(row), .col(col),
    .acc_go(acc_go), .acc_wr(acc_wr), .out_drop(out_drop),
    .ras_prev(ras_p), .cas_prev(cas_p)
  );

  dtpm_cell_array #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .DQW_B(DQW_B)
  ) u_cells (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .acc_go(acc_go), .acc_wr(acc_wr), .row(row), .col(col), .wdata(dq_s),
    .inj_en(inj_en), .inj_row(inj_row), .inj_col(inj_col), .inj_bit(inj_bit),
    .rd_go(rd_go), .rdata(rdata)
  );

  dtpm_dq_driver #(.DQ_W(DQ_W), .TEST_EXTRA_CYC(TEST_EXTRA_CYC)) u_drv (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .rd_go(rd_go), .rdata(rdata), .drop(out_drop),
    .dq_oe(dq_oe), .dq_out(dq_out)
  );

endmodule

// File: rtl/dram_ptest_checker.sv
module dram_ptest_checker #(
  parameter int DQ_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            test_mode,
  input logic            dq_oe,
  input logic [DQ_W-1:0] dq_out,
  input logic            ras_s,
  input logic            ras_p,
  input logic            cas_p,
  input logic            we_s,
  input logic            acc_go
);

  // R2: entry only while row strobe and write-enable are low
  a_r2_entry_needs_we_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> ($past(!ras_s) && $past(!we_s)));

  // R3: the flag moves only inside a row-strobe cycle
  a_r3_change_in_ras_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode != $past(test_mode)) |-> ($past(!ras_p) || $past(!ras_s)));

  // R12: data valid only while the column strobe is held low
  a_r12_oe_needs_cas: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !cas_p);

  // R12: bus reads zero when not enabled
  a_r12_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  // R11: normal read is valid two cycles after the column event
  a_r11_normal_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dq_oe) && !test_mode && !$past(test_mode, 2)) |-> $past(acc_go, 2));

  // R11: test read is later than the normal read
  a_r11_test_later: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dq_oe) && test_mode && $past(test_mode, 2)) |-> !$past(acc_go, 2));

endmodule

bind dram_ptest dram_ptest_checker #(.DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .dq_oe(dq_oe),
  .dq_out(dq_out), .ras_s(ras_s), .ras_p(ras_p), .cas_p(cas_p),
  .we_s(we_s), .acc_go(acc_go)
);

// File: tb/dram_ptest_bench.sv
module dram_ptest_bench;

  logic clk, rst_n, ras_n, cas_n, we_n, inj_en;
  logic [2:0] addr;
  logic [3:0] dq_in, dq_out;
  logic [1:0] inj_row, inj_bit;
  logic [2:0] inj_col;
  logic dq_oe, test_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dram_ptest u_dram_ptest (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .inj_en(inj_en), .inj_row(inj_row),
    .inj_col(inj_col), .inj_bit(inj_bit), .dq_out(dq_out), .dq_oe(dq_oe),
    .test_mode(test_mode)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {row[1:0], col[2:0], data[3:0]}
  localparam logic [8:0] VEC [6] = '{
    {2'd0, 3'd0, 4'h5}, {2'd0, 3'd7, 4'hC}, {2'd1, 3'd2, 4'h3},
    {2'd2, 3'd5, 4'h9}, {2'd3, 3'd1, 4'hE}, {2'd2, 3'd6, 4'h6}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_row(logic [1:0] r);
    addr = {1'b0, r}; tick(3); ras_n = 1'b0; tick(4);
  endtask

  task automatic close_row();
    ras_n = 1'b1; tick(6);
  endtask

  task automatic col_write(logic [2:0] c, logic [3:0] d);
    addr = c; dq_in = d; we_n = 1'b0; tick(3);
    cas_n = 1'b0; tick(6);
    check("R12 no output during write", dq_oe, 0);
    cas_n = 1'b1; tick(3); we_n = 1'b1; tick(3);
  endtask

  task automatic col_read(string req, logic [2:0] c, logic [3:0] exp, output int lat);
    addr = c; we_n = 1'b1; tick(3);
    cas_n = 1'b0; lat = 0;
    while (!dq_oe && lat < 20) begin tick(1); lat++; end
    tick(2);
    check(req, dq_out, exp);
    cas_n = 1'b1; tick(4);
    check("R12 output off after column release", {dq_oe, dq_out}, 0);
  endtask

  // mode 0 valid entry, 1 write-enable high, 2 late setup, 3 short hold
  task automatic cbr(int mode);
    cas_n = 1'b0;
    if (mode == 0 || mode == 3) we_n = 1'b0;
    tick(4);
    if (mode == 2) we_n = 1'b0;
    ras_n = 1'b0; tick(1);
    if (mode == 3) we_n = 1'b1;
    tick(8); ras_n = 1'b1; tick(1); cas_n = 1'b1; we_n = 1'b1; tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat, lat_n, lat_t;
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    addr = '0; dq_in = '0; inj_en = 1'b0; inj_row = '0; inj_col = '0; inj_bit = '0;
    tick(5);
    check("R1 reset state", {test_mode, dq_oe, dq_out}, 0);
    rst_n = 1'b1; tick(3);
    check("R1 after reset", {test_mode, dq_oe, dq_out}, 0);

    // R8: table walk, write then read back
    foreach (VEC[i]) begin
      open_row(VEC[i][8:7]); col_write(VEC[i][6:4], VEC[i][3:0]); close_row();
    end
    foreach (VEC[i]) begin
      open_row(VEC[i][8:7]); col_read("R8 normal read", VEC[i][6:4], VEC[i][3:0], lat); close_row();
    end

    // R8: fast page, several columns in one open row
    open_row(2'd3);
    col_write(3'd4, 4'h1); col_write(3'd5, 4'h2); col_write(3'd6, 4'h4);
    close_row();
    open_row(2'd3);
    col_read("R8 page read c4", 3'd4, 4'h1, lat);
    col_read("R8 page read c5", 3'd5, 4'h2, lat);
    col_read("R8 page read c6", 3'd6, 4'h4, lat);
    close_row();
    check("R3 flag unchanged by accesses", test_mode, 0);

    open_row(2'd0); col_read("R8 latency ref", 3'd0, 4'h5, lat_n); close_row();

    // R2 entry
    cbr(0);
    check("R2 test mode entered", test_mode, 1);

    // R9 pair write, R10 compressed read
    open_row(2'd1);
    col_write(3'd2, 4'hA);
    check("R3 flag held in access", test_mode, 1);
    col_read("R10 equal pair reads all ones", 3'd3, 4'hF, lat_t);
    close_row();
    check("R11 extra test latency", lat_t - lat_n, 1);

    // R13 inject a flip, R10 mismatch
    @(negedge clk);
    inj_row = 2'd1; inj_col = 3'd3; inj_bit = 2'd1; inj_en = 1'b1;
    @(negedge clk); inj_en = 1'b0;
    open_row(2'd1);
    col_read("R10 mismatch bit low", 3'd2, 4'hD, lat);
    col_read("R9 column bit0 ignored", 3'd3, 4'hD, lat);
    close_row();
    check("R3 flag held after reads", test_mode, 1);

    // R5 exit by row-only cycle
    addr = 3'd1; tick(3); ras_n = 1'b0; tick(8); ras_n = 1'b1; tick(6);
    check("R5 row-only exit", test_mode, 0);
    open_row(2'd1);
    col_read("R9 even cell written", 3'd2, 4'hA, lat);
    col_read("R13 odd cell flipped", 3'd3, 4'h8, lat);
    close_row();

    // R4 exit by refresh with write-enable high
    cbr(0);
    check("R2 re-entry", test_mode, 1);
    cbr(1);
    check("R4 refresh exit", test_mode, 0);

    // R6 late setup, R7 short hold
    cbr(2);
    check("R6 late setup no entry", test_mode, 0);
    cbr(3);
    check("R7 short hold no entry", test_mode, 0);
    cbr(0);
    cbr(2);
    check("R6 late setup clears flag", test_mode, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule